// File: doc/BRIEF.md
# PAL/SECAM Colour Standard Identification Sequencer

This block chooses, one field at a time, which colour standard a combined PAL/SECAM decoder should demodulate. With no force applied it searches. It enables one standard for a fixed number of fields, with the other standard off, and then switches to the other standard. At every field boundary it reads a per-field verdict from the colour-killer comparators. A PAL verdict is trusted at once and locks the decoder in PAL. A SECAM verdict is trusted only after a second look. The first SECAM hit is stored, PAL is then tried again, and a further SECAM hit is needed to confirm. From the start of a SECAM trial, SECAM is identified within four to six fields.

The sequencer has eight states. ST_PAL_SEARCH and ST_SEC_SEARCH form the plain alternating search. ST_PAL_RECHECK is the PAL trial that follows a stored SECAM hit. ST_SEC_CONFIRM is the confirming SECAM trial. ST_PAL_LOCK and ST_SEC_LOCK are the identified states. ST_FORCE_PAL and ST_FORCE_SEC hold the standard that an external force control selects.

The named transitions are:
- hit: a trial state moves to its lock or confirm path (PAL_SEARCH→PAL_LOCK, SEC_SEARCH→PAL_RECHECK, PAL_RECHECK→PAL_LOCK, SEC_CONFIRM→SEC_LOCK).
- timeout: a trial state moves to its successor once its fields are used up (PAL_SEARCH→SEC_SEARCH, SEC_SEARCH→PAL_SEARCH, PAL_RECHECK→SEC_CONFIRM, SEC_CONFIRM→PAL_SEARCH).
- retry: the trial state stays put and its field count restarts. This happens when the verdict is negative.
- loss: a lock state returns to PAL_SEARCH.
- force: any state moves to a force state.
- release: a force state returns to PAL_SEARCH.

A negative verdict means the line-alternation phase is wrong. On a retry the block raises a one-cycle request to invert that phase, and the trial then starts again.

Top module: `std_ident_seq`

## Requirements
- R1: While reset is held, and on leaving it, the block is in ST_PAL_SEARCH: pal_en=1, secam_en=0, std_is_pal=1, color_on=0, phase_flip=0.
- R2: With force_sel auto and no hits, the enabled standard alternates every TRIAL_FIELDS (default 2) field ticks. It starts with PAL. Exactly one of pal_en and secam_en is high at all times, and std_is_pal equals pal_en.
- R3: A field tick with pal_hit=1 in ST_PAL_SEARCH or ST_PAL_RECHECK moves the block to ST_PAL_LOCK on that clock edge (pal_en=1, color_on=1).
- R4: A secam_hit tick in ST_SEC_SEARCH stores the hit and moves to ST_PAL_RECHECK, with color_on still 0. After TRIAL_FIELDS ticks without a PAL hit the block enters ST_SEC_CONFIRM. A secam_hit tick there gives ST_SEC_LOCK (secam_en=1, std_is_pal=0, color_on=1). This takes four to six fields from the start of the SECAM trial.
- R5: If ST_SEC_CONFIRM spends TRIAL_FIELDS ticks without secam_hit, the block returns to ST_PAL_SEARCH and the stored hit is discarded. A later single SECAM hit then leads only to ST_PAL_RECHECK.
- R6: In a lock state, LOSS_FIELDS (default 2) consecutive ticks without that standard's hit flag return the block to ST_PAL_SEARCH with color_on=0. A single miss followed by a hit keeps the lock.
- R7: force_sel=2'b01 forces PAL and 2'b10 forces SECAM from the next clock edge, whatever the hit flags. color_on is 1 while forced. Returning to 2'b00 (or 2'b11, treated as auto) enters ST_PAL_SEARCH one edge later.
- R8: A tick in a trial state with id_neg=1 and no hit for the tested standard raises phase_flip for exactly the following cycle. The state is kept and the trial count restarts, so TRIAL_FIELDS further ticks are needed before a timeout.
- R9: The hit flag of the standard not under test is ignored, and all verdict flags are ignored in cycles without field_tick.
- R10: color_on is 1 only in ST_PAL_LOCK, ST_SEC_LOCK, ST_FORCE_PAL and ST_FORCE_SEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_sel | input | 2 | 00 auto, 01 force PAL, 10 force SECAM, 11 auto |
| field_tick | input | 1 | One-cycle pulse at each field boundary |
| pal_hit | input | 1 | PAL identified in the field just ended |
| secam_hit | input | 1 | SECAM identified in the field just ended |
| id_neg | input | 1 | Identification verdict negative in the field just ended |
| pal_en | output | 1 | PAL demodulation enabled |
| secam_en | output | 1 | SECAM demodulation enabled |
| std_is_pal | output | 1 | Standard flag, high for PAL, low for SECAM |
| color_on | output | 1 | Colour identified or forced |
| phase_flip | output | 1 | One-cycle request to invert line alternation |

## Verification
The in-line assertions check on every cycle several properties:
- the enables are mutually exclusive;
- state does not move between field ticks;
- a PAL hit and a confirming SECAM hit take effect in the next cycle;
- a hit in a lock state preserves the lock;
- force takes effect on the next edge;
- phase_flip follows a negative verdict;
- color_on appears only in lock or forced states;
- the field counters never run past their limits.

Only the bench scenarios can show the multi-field orderings: the two-field alternation period, the stored-then-confirmed SECAM path and the discard of that memory after a failed confirmation, loss after two misses but not after one, and the restart of the trial count after a retry.

// File: rtl/std_ident_pkg.sv
package std_ident_pkg;

    typedef enum logic [2:0] {
        ST_PAL_SEARCH  = 3'd0,
        ST_SEC_SEARCH  = 3'd1,
        ST_PAL_RECHECK = 3'd2,
        ST_SEC_CONFIRM = 3'd3,
        ST_PAL_LOCK    = 3'd4,
        ST_SEC_LOCK    = 3'd5,
        ST_FORCE_PAL   = 3'd6,
        ST_FORCE_SEC   = 3'd7
    } id_state_t;

    typedef enum logic [1:0] {
        FRC_AUTO  = 2'b00,
        FRC_PAL   = 2'b01,
        FRC_SEC   = 2'b10,
        FRC_AUTO2 = 2'b11
    } force_t;

endpackage

// File: rtl/std_ident_field_cnt.sv
module std_ident_field_cnt #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    // R2, R6: the controller never lets the count pass its limit
    a_r2_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < int'(LIMIT));

    a_r2_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !last);

endmodule

// File: rtl/std_ident_out_dec.sv
module std_ident_out_dec
    import std_ident_pkg::*;
(
    input  id_state_t state,
    output logic      pal_en,
    output logic      secam_en,
    output logic      std_is_pal,
    output logic      color_on
);
    always_comb begin
        pal_en   = 1'b0;
        color_on = 1'b0;
        unique case (state)
            ST_PAL_SEARCH:  begin pal_en = 1'b1; color_on = 1'b0; end
            ST_SEC_SEARCH:  begin pal_en = 1'b0; color_on = 1'b0; end
            ST_PAL_RECHECK: begin pal_en = 1'b1; color_on = 1'b0; end
            ST_SEC_CONFIRM: begin pal_en = 1'b0; color_on = 1'b0; end
            ST_PAL_LOCK:    begin pal_en = 1'b1; color_on = 1'b1; end
            ST_SEC_LOCK:    begin pal_en = 1'b0; color_on = 1'b1; end
            ST_FORCE_PAL:   begin pal_en = 1'b1; color_on = 1'b1; end
            ST_FORCE_SEC:   begin pal_en = 1'b0; color_on = 1'b1; end
        endcase
        secam_en   = ~pal_en;
        std_is_pal = pal_en;
    end
endmodule

// File: rtl/std_ident_seq.sv
module std_ident_seq
    import std_ident_pkg::*;
#(
    parameter int unsigned TRIAL_FIELDS = 2,
    parameter int unsigned LOSS_FIELDS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] force_sel,
    input  logic       field_tick,
    input  logic       pal_hit,
    input  logic       secam_hit,
    input  logic       id_neg,
    output logic       pal_en,
    output logic       secam_en,
    output logic       std_is_pal,
    output logic       color_on,
    output logic       phase_flip
);
    id_state_t state, state_nx;
    id_state_t hit_target, miss_target;

    logic frc_pal, frc_sec, frc_any;
    logic in_trial, in_lock, in_force;
    logic tested_pal, trial_hit, lock_hit;
    logic trial_last, loss_last;
    logic trial_clr, trial_inc, loss_clr, loss_inc;
    logic flip_nx, flip_q;

    assign frc_pal = (force_sel == FRC_PAL);
    assign frc_sec = (force_sel == FRC_SEC);
    assign frc_any = frc_pal | frc_sec;

    assign in_trial   = (state == ST_PAL_SEARCH) || (state == ST_SEC_SEARCH) ||
                        (state == ST_PAL_RECHECK) || (state == ST_SEC_CONFIRM);
    assign in_lock    = (state == ST_PAL_LOCK) || (state == ST_SEC_LOCK);
    assign in_force   = (state == ST_FORCE_PAL) || (state == ST_FORCE_SEC);
    assign tested_pal = (state == ST_PAL_SEARCH) || (state == ST_PAL_RECHECK);
    assign trial_hit  = tested_pal ? pal_hit : secam_hit;
    assign lock_hit   = (state == ST_PAL_LOCK) ? pal_hit : secam_hit;

    // where each trial state goes on a hit and on running out of fields
    always_comb begin
        hit_target  = ST_PAL_LOCK;
        miss_target = ST_SEC_SEARCH;
        unique case (state)
            ST_PAL_SEARCH:  begin hit_target = ST_PAL_LOCK;    miss_target = ST_SEC_SEARCH;  end
            ST_SEC_SEARCH:  begin hit_target = ST_PAL_RECHECK; miss_target = ST_PAL_SEARCH;  end
            ST_PAL_RECHECK: begin hit_target = ST_PAL_LOCK;    miss_target = ST_SEC_CONFIRM; end
            ST_SEC_CONFIRM: begin hit_target = ST_SEC_LOCK;    miss_target = ST_PAL_SEARCH;  end
            ST_PAL_LOCK,
            ST_SEC_LOCK,
            ST_FORCE_PAL,
            ST_FORCE_SEC:   begin hit_target = state;          miss_target = state;          end
        endcase
    end

    always_comb begin
        state_nx  = state;
        flip_nx   = 1'b0;
        trial_inc = 1'b0;
        loss_inc  = 1'b0;
        loss_clr  = 1'b1;
        if (frc_pal) begin
            state_nx = ST_FORCE_PAL;
        end else if (frc_sec) begin
            state_nx = ST_FORCE_SEC;
        end else if (in_force) begin
            state_nx = ST_PAL_SEARCH;
        end else if (in_trial) begin
            if (field_tick) begin
                if (trial_hit)
                    state_nx = hit_target;
                else if (id_neg)
                    flip_nx = 1'b1;
                else if (trial_last)
                    state_nx = miss_target;
                else
                    trial_inc = 1'b1;
            end
        end else if (in_lock) begin
            loss_clr = 1'b0;
            if (field_tick) begin
                if (lock_hit)
                    loss_clr = 1'b1;
                else if (loss_last) begin
                    state_nx = ST_PAL_SEARCH;
                    loss_clr = 1'b1;
                end else
                    loss_inc = 1'b1;
            end
        end
        trial_clr = (state_nx != state) || flip_nx || !in_trial;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_PAL_SEARCH;
            flip_q <= 1'b0;
        end else begin
            state  <= state_nx;
            flip_q <= flip_nx;
        end
    end

    std_ident_field_cnt #(.LIMIT(TRIAL_FIELDS)) u_trial_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trial_clr),
        .inc   (trial_inc),
        .last  (trial_last)
    );

    std_ident_field_cnt #(.LIMIT(LOSS_FIELDS)) u_loss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (loss_clr),
        .inc   (loss_inc),
        .last  (loss_last)
    );

    std_ident_out_dec u_out_dec (
        .state      (state),
        .pal_en     (pal_en),
        .secam_en   (secam_en),
        .std_is_pal (std_is_pal),
        .color_on   (color_on)
    );

    assign phase_flip = flip_q;

    a_r2_one_std: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_en != secam_en) && (std_is_pal == pal_en));

    a_r9_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_tick && !frc_any && !in_force) |=> $stable(state));

    a_r3_pal_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (field_tick && pal_hit && !frc_any && pal_en && !color_on) |=> (pal_en && color_on));

    a_r4_sec_confirms: assert property (@(posedge clk) disable iff (!rst_n)
        (field_tick && secam_hit && !frc_any && state == ST_SEC_CONFIRM) |=> (color_on && !std_is_pal));

    a_r6_hit_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (field_tick && pal_hit && !frc_any && state == ST_PAL_LOCK) |=> (state == ST_PAL_LOCK));

    a_r7_force_pal: assert property (@(posedge clk) disable iff (!rst_n)
        frc_pal |=> (pal_en && color_on));

    a_r7_force_sec: assert property (@(posedge clk) disable iff (!rst_n)
        frc_sec |=> (secam_en && color_on));

    a_r8_flip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        phase_flip |-> ($past(field_tick) && $past(id_neg) && !$past(frc_any)));

    a_r10_color_states: assert property (@(posedge clk) disable iff (!rst_n)
        color_on |-> (in_lock || in_force));

endmodule

// File: tb/std_ident_seq_bench.sv
module std_ident_seq_bench;
    localparam int CLK_PERIOD = 10;

    localparam int M_PS = 0, M_SS = 1, M_PR = 2, M_SC = 3,
                   M_PL = 4, M_SL = 5, M_FP = 6, M_FS = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] force_sel = 2'b00;
    logic       field_tick = 1'b0;
    logic       pal_hit = 1'b0;
    logic       secam_hit = 1'b0;
    logic       id_neg = 1'b0;
    logic       pal_en, secam_en, std_is_pal, color_on, phase_flip;

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";

    int m_st = M_PS;
    int m_cnt = 0;
    int m_miss = 0;
    bit m_flip = 0;

    std_ident_seq u_std_ident_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_sel  (force_sel),
        .field_tick (field_tick),
        .pal_hit    (pal_hit),
        .secam_hit  (secam_hit),
        .id_neg     (id_neg),
        .pal_en     (pal_en),
        .secam_en   (secam_en),
        .std_is_pal (std_is_pal),
        .color_on   (color_on),
        .phase_flip (phase_flip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_PS; m_cnt = 0; m_miss = 0; m_flip = 0;
        end else begin
            m_flip = 0;
            if (force_sel == 2'b01) begin
                m_st = M_FP; m_cnt = 0; m_miss = 0;
            end else if (force_sel == 2'b10) begin
                m_st = M_FS; m_cnt = 0; m_miss = 0;
            end else if (m_st == M_FP || m_st == M_FS) begin
                m_st = M_PS; m_cnt = 0; m_miss = 0;
            end else if (field_tick) begin
                if (m_st == M_PL || m_st == M_SL) begin
                    if ((m_st == M_PL) ? pal_hit : secam_hit)
                        m_miss = 0;
                    else begin
                        m_miss++;
                        if (m_miss >= 2) begin m_st = M_PS; m_miss = 0; m_cnt = 0; end
                    end
                end else begin
                    bit hit;
                    hit = (m_st == M_PS || m_st == M_PR) ? pal_hit : secam_hit;
                    if (hit) begin
                        m_cnt = 0; m_miss = 0;
                        case (m_st)
                            M_PS: m_st = M_PL;
                            M_SS: m_st = M_PR;
                            M_PR: m_st = M_PL;
                            default: m_st = M_SL;
                        endcase
                    end else if (id_neg) begin
                        m_flip = 1; m_cnt = 0;
                    end else begin
                        m_cnt++;
                        if (m_cnt >= 2) begin
                            m_cnt = 0;
                            case (m_st)
                                M_PS: m_st = M_SS;
                                M_SS: m_st = M_PS;
                                M_PR: m_st = M_SC;
                                default: m_st = M_PS;
                            endcase
                        end
                    end
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_pal, e_col;
            e_pal = (m_st == M_PS || m_st == M_PR || m_st == M_PL || m_st == M_FP);
            e_col = (m_st == M_PL || m_st == M_SL || m_st == M_FP || m_st == M_FS);
            vectors++;
            if (pal_en !== e_pal || secam_en !== !e_pal || std_is_pal !== e_pal ||
                color_on !== e_col || phase_flip !== m_flip) begin
                errors++;
                $display("FAIL %s t=%0t actual pal/sec/std/col/flip=%b%b%b%b%b expected=%b%b%b%b%b",
                         cur_req, $time, pal_en, secam_en, std_is_pal, color_on, phase_flip,
                         e_pal, !e_pal, e_pal, e_col, m_flip);
            end
        end
    end

    task automatic expect_out(input string req, input bit pal, input bit col, input bit flip);
        vectors++;
        if (pal_en !== pal || secam_en !== !pal || color_on !== col || phase_flip !== flip) begin
            errors++;
            $display("FAIL %s explicit t=%0t actual pal/sec/col/flip=%b%b%b%b expected=%b%b%b%b",
                     req, $time, pal_en, secam_en, color_on, phase_flip, pal, !pal, col, flip);
        end
    endtask

    task automatic field(input bit p, input bit s, input bit n);
        repeat (3) @(negedge clk);
        pal_hit = p; secam_hit = s; id_neg = n; field_tick = 1'b1;
        @(negedge clk);
        field_tick = 1'b0; pal_hit = 1'b0; secam_hit = 1'b0; id_neg = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1"; expect_out("R1", 1, 0, 0);

        cur_req = "R2";
        field(0, 0, 0); expect_out("R2", 1, 0, 0);
        field(0, 0, 0); expect_out("R2", 0, 0, 0);
        field(0, 0, 0); field(0, 0, 0); expect_out("R2", 1, 0, 0);

        cur_req = "R9";
        field(0, 1, 0); expect_out("R9", 1, 0, 0);
        pal_hit = 1'b1; repeat (5) @(negedge clk); pal_hit = 1'b0;
        expect_out("R9", 1, 0, 0);
        field(0, 0, 0); expect_out("R9", 0, 0, 0);
        field(1, 0, 0); expect_out("R9", 0, 0, 0);
        field(0, 0, 0); expect_out("R2", 1, 0, 0);
        field(0, 0, 0); field(0, 0, 0); expect_out("R2", 0, 0, 0);

        cur_req = "R4";
        field(0, 1, 0); expect_out("R4", 1, 0, 0);
        field(0, 0, 0); field(0, 0, 0); expect_out("R4", 0, 0, 0);
        field(0, 1, 0); expect_out("R4", 0, 1, 0);

        cur_req = "R6";
        field(0, 0, 0); expect_out("R6", 0, 1, 0);
        field(0, 1, 0); field(0, 0, 0); expect_out("R6", 0, 1, 0);
        field(0, 0, 0); expect_out("R6", 1, 0, 0);

        cur_req = "R3";
        field(1, 0, 0); expect_out("R3", 1, 1, 0);
        cur_req = "R6";
        field(0, 0, 0); field(0, 0, 0); expect_out("R6", 1, 0, 0);

        cur_req = "R5";
        field(0, 0, 0); field(0, 0, 0);
        field(0, 1, 0); field(0, 0, 0); field(0, 0, 0); expect_out("R5", 0, 0, 0);
        field(0, 0, 0); field(0, 0, 0); expect_out("R5", 1, 0, 0);
        field(0, 0, 0); field(0, 0, 0);
        field(0, 1, 0); expect_out("R5", 1, 0, 0);

        cur_req = "R3";
        field(1, 0, 0); expect_out("R3", 1, 1, 0);
        field(0, 0, 0); field(0, 0, 0); expect_out("R10", 1, 0, 0);

        cur_req = "R8";
        field(0, 0, 1); expect_out("R8", 1, 0, 1);
        @(negedge clk); expect_out("R8", 1, 0, 0);
        field(0, 0, 0); expect_out("R8", 1, 0, 0);
        field(0, 0, 0); expect_out("R8", 0, 0, 0);
        field(0, 0, 0); field(0, 0, 0);

        cur_req = "R7";
        force_sel = 2'b01; @(negedge clk); expect_out("R7", 1, 1, 0);
        field(0, 1, 1); expect_out("R7", 1, 1, 0);
        force_sel = 2'b10; @(negedge clk); expect_out("R7", 0, 1, 0);
        field(1, 0, 0); expect_out("R7", 0, 1, 0);
        force_sel = 2'b00; @(negedge clk); expect_out("R7", 1, 0, 0);
        force_sel = 2'b11;
        field(0, 0, 0); field(0, 0, 0); expect_out("R7", 0, 0, 0);
        force_sel = 2'b00;
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule